// File: doc/BRIEF.md
# Excess-One Carry Select Adder

This block adds two N-bit unsigned operands and a carry-in, returning an N-bit sum and a carry-out. The operands are split into bit groups. The lowest group is an ordinary ripple adder fed by the external carry-in. Every higher group ripples its slice once, assuming no incoming carry. It then forms the "carry arrived" alternative by incrementing that ripple result, group carry-out included, by one. The real carry entering the group chooses between the two alternatives. No second ripple adder is used.

Group sizing is a parameter. In square-root sizing the groups grow toward the most significant end: 2, 2, 3, 4, 5 bits for a 16-bit adder. Each later group grows by one more bit, and the top group is cut short so the widths add up to N. This lets a group's local ripple finish at about the time its select carry arrives. Uniform sizing uses equal groups of a set width instead. The arithmetic is combinational. The result is captured in an output register, so sum and carry-out appear one clock after the operands are sampled.

Top module: `csel_adder`

## Requirements
- R1: One clock edge after the operands are sampled, `sum_o` equals the low N bits of `a_i + b_i + cin_i`.
- R2: On that same cycle, `cout_o` equals bit N of the (N+1)-bit total `a_i + b_i + cin_i`.
- R3: While `rst_n` is low, `sum_o` and `cout_o` are held at zero. They are still zero on the first edge at which `rst_n` is seen high.
- R4: A carry produced in the lowest group reaches the sum bit and the carry-out above every group boundary. For example, all-ones plus one with carry-in 0, or all-ones plus zero with carry-in 1, both give a sum of zero and a carry-out of 1.
- R5: When a group's no-carry ripple result is all ones and a carry enters it, the group's result wraps to zero and passes a carry upward. When that ripple result has a zero bit, only the bits up to and including the lowest zero are inverted.
- R6: Square-root sizing (`SQRT_SIZING`=1) and uniform sizing (`SQRT_SIZING`=0, groups of `UNI_W` bits) give identical results for every input.
- R7: R1 and R2 hold for N = 8, 16 and 64 with the same description. The 8-bit square-root split is 2, 2, 3, 1.
- R8: Zero plus zero with carry-in 0 gives sum zero and carry-out 0. All-ones plus all-ones with carry-in 1 gives a sum of all ones and carry-out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset that clears the output register |
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| cin_i | input | 1 | Carry into the least significant bit |
| sum_o | output | N | Registered sum, modulo 2^N |
| cout_o | output | 1 | Registered carry out of the most significant bit |

## Verification
Suppose a group's select carry is wrong, or its increment path flips the wrong bits. The error shows at the ports on the very next cycle: the sum bits of that group and of every group above it are wrong. Often the carry-out is wrong as well. A fault that only acts when a carry crosses a boundary, or when a group's ripple result is all ones, stays hidden under random operands. Directed operands therefore drive a carry through every boundary and force group wrap-around. The square-root, uniform, 8-bit and 64-bit builds are all compared against one integer reference on every clock.

// File: rtl/csel_pkg.sv
package csel_pkg;

    // Width of group idx; 0 once idx is past the last group.
    function automatic int grp_w(int n, int sqrt_mode, int uw, int idx);
        int used;
        int w;
        used = 0;
        w = 0;
        for (int k = 0; k <= idx; k++) begin
            if (used >= n) begin
                w = 0;
            end else begin
                if (sqrt_mode != 0) w = (k + 1 < 2) ? 2 : ((k + 1 > 2) ? k + 1 : 2);
                else                w = uw;
                if (w > n - used) w = n - used;
            end
            used = used + w;
        end
        return w;
    endfunction

    // Bit position of the lowest bit of group idx.
    function automatic int grp_lsb(int n, int sqrt_mode, int uw, int idx);
        int acc;
        acc = 0;
        for (int k = 0; k < idx; k++) acc = acc + grp_w(n, sqrt_mode, uw, k);
        return acc;
    endfunction

    // Number of groups needed to cover n bits.
    function automatic int grp_count(int n, int sqrt_mode, int uw);
        int cnt;
        int used;
        cnt = 0;
        used = 0;
        while (used < n) begin
            used = used + grp_w(n, sqrt_mode, uw, cnt);
            cnt = cnt + 1;
        end
        return cnt;
    endfunction

endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] chain;

    assign chain[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic half;
        assign half         = a_i[i] ^ b_i[i];
        assign sum_o[i]     = half ^ chain[i];
        assign chain[i + 1] = (a_i[i] & b_i[i]) | (half & chain[i]);
    end

    assign cout_o = chain[W];
endmodule

// File: rtl/csel_excess1.sv
module csel_excess1 #(
    parameter int W = 5
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] inc_o
);
    // flip[i] is high when every bit below i is one: bit i is inverted.
    logic [W-1:0] flip;

    assign flip[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign inc_o[i] = val_i[i] ^ flip[i];
        if (i < W - 1) begin : g_next
            assign flip[i + 1] = flip[i] & val_i[i];
        end
    end
endmodule

// File: rtl/csel_group.sv
module csel_group #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sel_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W-1:0] zero_sum;
    logic         zero_cy;
    logic [W:0]   one_res;

    csel_ripple #(.W(W)) u_rip (
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (1'b0),
        .sum_o (zero_sum),
        .cout_o(zero_cy)
    );

    csel_excess1 #(.W(W + 1)) u_inc (
        .val_i({zero_cy, zero_sum}),
        .inc_o(one_res)
    );

    always_comb begin
        if (sel_i) begin
            sum_o  = one_res[W-1:0];
            cout_o = one_res[W];
        end else begin
            sum_o  = zero_sum;
            cout_o = zero_cy;
        end
    end
endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
    parameter int N           = 16,
    parameter int SQRT_SIZING = 1,
    parameter int UNI_W       = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         cin_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o
);
    localparam int NG = csel_pkg::grp_count(N, SQRT_SIZING, UNI_W);

    typedef struct packed {
        logic [N-1:0] sum;
        logic         cy;
    } res_t;

    res_t         res_d, res_q;
    logic [NG:0]  carry;
    logic [N-1:0] comb_sum;

    assign carry[0] = cin_i;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam int LSB = csel_pkg::grp_lsb(N, SQRT_SIZING, UNI_W, g);
        localparam int W   = csel_pkg::grp_w(N, SQRT_SIZING, UNI_W, g);
        if (g == 0) begin : g_base
            csel_ripple #(.W(W)) u_base (
                .a_i   (a_i[LSB +: W]),
                .b_i   (b_i[LSB +: W]),
                .cin_i (carry[0]),
                .sum_o (comb_sum[LSB +: W]),
                .cout_o(carry[1])
            );
        end else begin : g_sel
            csel_group #(.W(W)) u_grp (
                .a_i   (a_i[LSB +: W]),
                .b_i   (b_i[LSB +: W]),
                .sel_i (carry[g]),
                .sum_o (comb_sum[LSB +: W]),
                .cout_o(carry[g + 1])
            );
        end
    end

    always_comb begin
        res_d     = res_q;
        res_d.sum = comb_sum;
        res_d.cy  = carry[NG];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign sum_o  = res_q.sum;
    assign cout_o = res_q.cy;

    // Integer reference total used only by the checks below.
    logic [N:0] chk_total;
    assign chk_total = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i};

    assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sum_o == $past(chk_total[N-1:0])))
        else $error("sum register differs from reference total");

    assert_cout_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cout_o == $past(chk_total[N])))
        else $error("carry-out register differs from reference total");

    assert_reset_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sum_o == '0 && !cout_o))
        else $error("outputs not cleared by reset");

    for (genvar g = 1; g < NG; g++) begin : g_chk
        localparam int BL = csel_pkg::grp_lsb(N, SQRT_SIZING, UNI_W, g);
        // R4: select carry entering each group matches the true carry at that bit
        assert_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
            carry[g] == (a_i[BL] ^ b_i[BL] ^ chk_total[BL]))
            else $error("select carry wrong at group boundary");
    end
endmodule

// File: tb/csel_adder_test.sv
`timescale 1ns/1ps
module csel_adder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a64 = '0, b64 = '0;
    logic        cin = 1'b0;

    logic [15:0] s16, s16u;
    logic [7:0]  s8;
    logic [63:0] s64;
    logic        c16, c16u, c8, c64;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [63:0] a;
        logic [63:0] b;
        logic        c;
        string       tag;
    } vec_t;
    vec_t pend[$];

    always #2 clk = ~clk;

    csel_adder #(.N(16), .SQRT_SIZING(1), .UNI_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .a_i(a64[15:0]), .b_i(b64[15:0]),
        .cin_i(cin), .sum_o(s16), .cout_o(c16));
    csel_adder #(.N(16), .SQRT_SIZING(0), .UNI_W(4)) uut_uni (
        .clk(clk), .rst_n(rst_n), .a_i(a64[15:0]), .b_i(b64[15:0]),
        .cin_i(cin), .sum_o(s16u), .cout_o(c16u));
    csel_adder #(.N(8), .SQRT_SIZING(1), .UNI_W(4)) uut_8 (
        .clk(clk), .rst_n(rst_n), .a_i(a64[7:0]), .b_i(b64[7:0]),
        .cin_i(cin), .sum_o(s8), .cout_o(c8));
    csel_adder #(.N(64), .SQRT_SIZING(1), .UNI_W(4)) uut_64 (
        .clk(clk), .rst_n(rst_n), .a_i(a64), .b_i(b64),
        .cin_i(cin), .sum_o(s64), .cout_o(c64));

    task automatic check(string tag, string who, logic [64:0] act, logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, who, act, exp);
        end
    endtask

    // Compare results of the oldest pending vector (R1, R2, R6, R7).
    task automatic compare_pending();
        vec_t v;
        logic [64:0] t64;
        logic [16:0] t16;
        logic [8:0]  t8;
        if (pend.size() == 0) return;
        v   = pend.pop_front();
        t64 = {1'b0, v.a} + {1'b0, v.b} + 65'(v.c);
        t16 = {1'b0, v.a[15:0]} + {1'b0, v.b[15:0]} + 17'(v.c);
        t8  = {1'b0, v.a[7:0]} + {1'b0, v.b[7:0]} + 9'(v.c);
        check({v.tag, "/R1/R2"}, "sqrt16", 65'({c16, s16}), 65'(t16));
        check({v.tag, "/R6"}, "uniform16", 65'({c16u, s16u}), 65'(t16));
        check({v.tag, "/R7"}, "sqrt8", 65'({c8, s8}), 65'(t8));
        check({v.tag, "/R7"}, "sqrt64", {c64, s64}, t64);
    endtask

    task automatic step(logic [63:0] a, logic [63:0] b, logic c, string tag);
        vec_t v;
        @(negedge clk);
        compare_pending();
        a64 = a; b64 = b; cin = c;
        v.a = a; v.b = b; v.c = c; v.tag = tag;
        pend.push_back(v);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : main
        // R3: outputs held at zero under reset despite busy inputs
        a64 = '1; b64 = 64'h1; cin = 1'b1;
        repeat (3) @(negedge clk);
        check("R3", "sqrt16", 65'({c16, s16}), 65'd0);
        check("R3", "uniform16", 65'({c16u, s16u}), 65'd0);
        check("R3", "sqrt8", 65'({c8, s8}), 65'd0);
        check("R3", "sqrt64", {c64, s64}, 65'd0);
        rst_n = 1'b1;

        step('0, '0, 1'b0, "R8");
        step('1, '1, 1'b1, "R8");
        step('1, 64'h1, 1'b0, "R4");
        step('1, '0, 1'b1, "R4");
        step(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, "R4");
        step(64'h0000_0000_0000_00FF, '0, 1'b1, "R5");
        step(64'h0F0F_0F0F_0F0F_0F0F, 64'h00F1_00F1_00F1_00F1, 1'b0, "R5");
        step(64'h0000_0000_0000_001F, 64'h0000_0000_0000_0060, 1'b1, "R5");
        step(64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, "R5");
        step(64'h8000_0000_0000_8000, 64'h8000_0000_0000_8000, 1'b0, "R2");
        for (int i = 0; i < 300; i++) begin
            step({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1");
        end
        @(negedge clk);
        compare_pending();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule